// File: doc/BRIEF.md
# Synchronous serial transmit buffer and underrun detector

This block controls the transmit side of a clocked synchronous serial port. It sits between a transmit FIFO and the serial shift register. A second transmit buffer holds the next byte. An external engine reports two events: that the shifter has finished its current word, and that the next transfer clock is due. On each such clock with the shifter idle, the block hands the shifter a word. The word comes from the second buffer, or from the FIFO head when the buffer is empty. The FIFO also refills the buffer whenever the buffer has room. Software writes go into the buffer directly only while the FIFO is switched off.

When a transfer clock arrives and no word is available, the port is starved. If the port runs in I/O interface mode with an externally supplied clock and double buffering on, the block raises a sticky underrun flag. That flag shares one status bit with the receive parity-error flag of UART mode, and the current mode selects which of the two the bit shows. A receive overrun flag is kept as well. It is suppressed when the port drives its own clock in I/O mode. Reading the status register clears all flags.

Top module: `sio_txbuf_ctrl`

## Requirements
- R1: After reset, `shift_load`, `buf_full`, `stat_err`, `stat_ovr` and `fifo_pop` are all 0.
- R2: A `sclk_next` pulse while the shifter is idle (never loaded, loaded and `shift_done` seen since, or `shift_done` in the same cycle) and with `buf_full`=1 gives `shift_load`=1 with `shift_data` equal to the buffered word in the next cycle, and the buffer becomes empty unless it is refilled in that cycle.
- R3: With `fifo_en`=1 and `fifo_empty`=0, `fifo_pop` is 1 in the same cycle whenever the buffer is empty or is being handed to the shifter. The buffer then takes `fifo_data`. A `sclk_next` with the shifter idle, an empty buffer and FIFO data loads `fifo_data` straight into the shifter.
- R4: A `wr_valid` write is taken into the buffer only when `fifo_en`=0 and the buffer is empty or being handed to the shifter in that cycle. Any other write is ignored, and `buf_full` and the buffered word stay unchanged.
- R5: When `mode_io`=1, `clk_is_input`=1 and `dbuf_en`=1, a `sclk_next` with the shifter idle, the buffer empty and no FIFO data sets the underrun flag. The flag is visible on `stat_err` one cycle later while `mode_io`=1.
- R6: With `clk_is_input`=0 the underrun flag is never set.
- R7: With `dbuf_en`=0 the underrun flag is never set.
- R8: `stat_err` shows the underrun flag when `mode_io`=1 and the parity flag when `mode_io`=0. `par_err` sets the parity flag only when `mode_io`=0.
- R9: `stat_rd` clears the underrun, parity and overrun flags in the next cycle. A set event in the same cycle wins, and that flag stays 1.
- R10: `ovr_evt` sets `stat_ovr` in the next cycle, except when `mode_io`=1 and `clk_is_input`=0.
- R11: A `sclk_next` while the shifter is busy (loaded, with no `shift_done` since) neither loads the shifter nor raises underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_io | input | 1 | 1 = I/O interface mode, 0 = UART mode |
| clk_is_input | input | 1 | 1 = serial clock supplied externally |
| dbuf_en | input | 1 | Double-buffer (second transmit buffer) enable |
| fifo_en | input | 1 | Transmit FIFO enable |
| fifo_empty | input | 1 | Transmit FIFO holds no word |
| fifo_data | input | DATA_W | Transmit FIFO head word |
| fifo_pop | output | 1 | Consume the FIFO head this cycle |
| wr_valid | input | 1 | Software write strobe to the buffer |
| wr_data | input | DATA_W | Software write word |
| shift_done | input | 1 | Shifter finished its current word |
| sclk_next | input | 1 | Next transfer clock is due |
| par_err | input | 1 | Receive parity mismatch event |
| ovr_evt | input | 1 | Receive overrun event |
| stat_rd | input | 1 | Status register read strobe |
| shift_load | output | 1 | Load pulse to the shifter |
| shift_data | output | DATA_W | Word for the shifter |
| buf_full | output | 1 | Second buffer holds a word |
| stat_err | output | 1 | Shared status bit 3: underrun or parity error |
| stat_ovr | output | 1 | Overrun flag |

## Verification
`fifo_pop` is combinational, so it is due in the same cycle as the inputs that cause it. The bench samples it a short delay after it drives the inputs. `shift_load`, `shift_data`, `buf_full` and all three flags are registered, so each is due one clock edge after its stimulus. The bench drives every input on the falling edge. It advances its reference model at the rising edge and compares the registered outputs at the following falling edge. `stat_err` is a mux of registered flags steered by the live `mode_io`, so its expected value uses the mode applied at sampling time.

// File: rtl/sio_txbuf_pkg.sv
package sio_txbuf_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BUF  = 2'd1,
        SRC_FIFO = 2'd2
    } load_src_e;

    typedef struct packed {
        logic unr;
        logic par;
        logic ovr;
    } flags_t;

endpackage

// File: rtl/sio_txbuf_slot.sv
module sio_txbuf_slot
    import sio_txbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shift_done,
    input  logic              sclk_next,
    output logic              fifo_pop_o,
    output logic              starve_o,
    output logic              shift_load_o,
    output logic [DATA_W-1:0] shift_data_o,
    output logic              buf_full_o
);

    typedef struct packed {
        logic [DATA_W-1:0] buf_data;
        logic              buf_vld;
        logic              busy;
        logic              load;
        logic [DATA_W-1:0] ldata;
    } slot_t;

    slot_t     st_d, st_q;
    load_src_e src;
    logic      idle, req, fifo_has, buf_free, pop_refill;

    always_comb begin
        st_d       = st_q;
        src        = SRC_NONE;
        idle       = !st_q.busy || shift_done;
        req        = sclk_next && idle;
        fifo_has   = fifo_en && !fifo_empty;
        if (req) begin
            if (st_q.buf_vld)  src = SRC_BUF;
            else if (fifo_has) src = SRC_FIFO;
        end
        starve_o   = req && (src == SRC_NONE);
        buf_free   = !st_q.buf_vld || (src == SRC_BUF);
        pop_refill = buf_free && fifo_has && (src != SRC_FIFO);
        fifo_pop_o = pop_refill || (src == SRC_FIFO);

        st_d.load = (src != SRC_NONE);
        case (src)
            SRC_BUF:  st_d.ldata = st_q.buf_data;
            SRC_FIFO: st_d.ldata = fifo_data;
            default:  st_d.ldata = st_q.ldata;
        endcase

        if (pop_refill) begin
            st_d.buf_vld  = 1'b1;
            st_d.buf_data = fifo_data;
        end else if (buf_free && !fifo_en && wr_valid) begin
            st_d.buf_vld  = 1'b1;
            st_d.buf_data = wr_data;
        end else if (src == SRC_BUF) begin
            st_d.buf_vld  = 1'b0;
        end

        if (st_d.load)       st_d.busy = 1'b1;
        else if (shift_done) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shift_load_o = st_q.load;
    assign shift_data_o = st_q.ldata;
    assign buf_full_o   = st_q.buf_vld;

    // R3: the FIFO is only consumed when it is enabled and holds a word
    a_r3_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> (fifo_en && !fifo_empty));

    // R2: a shifter load always follows a transfer clock
    a_r2_load_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load_o |-> $past(sclk_next));

    // R11: a busy shifter ignores the transfer clock
    a_r11_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_load_o && !shift_done) |=> !shift_load_o);

    // R4: a held word never disappears without a transfer clock
    a_r4_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full_o && !sclk_next) |=> buf_full_o);

endmodule

// File: rtl/sio_txbuf_flags.sv
module sio_txbuf_flags
    import sio_txbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_io,
    input  logic clk_is_input,
    input  logic dbuf_en,
    input  logic starve,
    input  logic par_err,
    input  logic ovr_evt,
    input  logic stat_rd,
    output logic stat_err_o,
    output logic stat_ovr_o
);

    flags_t fl_d, fl_q;
    logic   unr_set, par_set, ovr_set;

    always_comb begin
        unr_set = mode_io && clk_is_input && dbuf_en && starve;
        par_set = !mode_io && par_err;
        ovr_set = ovr_evt && !(mode_io && !clk_is_input);
        fl_d.unr = unr_set || (fl_q.unr && !stat_rd);
        fl_d.par = par_set || (fl_q.par && !stat_rd);
        fl_d.ovr = ovr_set || (fl_q.ovr && !stat_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign stat_err_o = mode_io ? fl_q.unr : fl_q.par;
    assign stat_ovr_o = fl_q.ovr;

    // R5: a starved clock in the detecting configuration raises underrun
    a_r5_unr_on_starve: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_io && clk_is_input && dbuf_en && starve) |=> fl_q.unr);

    // R6: underrun needs an external serial clock
    a_r6_unr_needs_clk_in: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.unr) |-> $past(clk_is_input));

    // R7: underrun needs double buffering
    a_r7_unr_needs_dbuf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.unr) |-> $past(dbuf_en));

    // R9: a read with no new event clears underrun
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !unr_set) |=> !fl_q.unr);

    // R10: overrun is suppressed while the port drives its own clock in I/O mode
    a_r10_no_ovr_clk_out: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.ovr) |-> $past(!(mode_io && !clk_is_input)));

endmodule

// File: rtl/sio_txbuf_ctrl.sv
module sio_txbuf_ctrl
    import sio_txbuf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_io,
    input  logic              clk_is_input,
    input  logic              dbuf_en,
    input  logic              fifo_en,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shift_done,
    input  logic              sclk_next,
    input  logic              par_err,
    input  logic              ovr_evt,
    input  logic              stat_rd,
    output logic              shift_load,
    output logic [DATA_W-1:0] shift_data,
    output logic              buf_full,
    output logic              stat_err,
    output logic              stat_ovr
);

    logic starve;

    sio_txbuf_slot #(.DATA_W(DATA_W)) slot_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_en      (fifo_en),
        .fifo_empty   (fifo_empty),
        .fifo_data    (fifo_data),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .shift_done   (shift_done),
        .sclk_next    (sclk_next),
        .fifo_pop_o   (fifo_pop),
        .starve_o     (starve),
        .shift_load_o (shift_load),
        .shift_data_o (shift_data),
        .buf_full_o   (buf_full)
    );

    sio_txbuf_flags flags_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_io      (mode_io),
        .clk_is_input (clk_is_input),
        .dbuf_en      (dbuf_en),
        .starve       (starve),
        .par_err      (par_err),
        .ovr_evt      (ovr_evt),
        .stat_rd      (stat_rd),
        .stat_err_o   (stat_err),
        .stat_ovr_o   (stat_ovr)
    );

endmodule

// File: tb/sio_txbuf_ctrl_tb.sv
module sio_txbuf_ctrl_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_io = 0, clk_is_input = 0, dbuf_en = 0, fifo_en = 0;
    logic          fifo_empty = 1;
    logic [DW-1:0] fifo_data = '0;
    logic          wr_valid = 0;
    logic [DW-1:0] wr_data = '0;
    logic          shift_done = 0, sclk_next = 0, par_err = 0, ovr_evt = 0, stat_rd = 0;
    logic          fifo_pop, shift_load, buf_full, stat_err, stat_ovr;
    logic [DW-1:0] shift_data;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R5";

    // reference model state
    logic          m_vld = 0, m_busy = 0, m_unr = 0, m_par = 0, m_ovr = 0, m_load = 0;
    logic [DW-1:0] m_buf = '0, m_ldata = '0;

    always #10 clk = ~clk;

    sio_txbuf_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_io(mode_io), .clk_is_input(clk_is_input),
        .dbuf_en(dbuf_en), .fifo_en(fifo_en), .fifo_empty(fifo_empty),
        .fifo_data(fifo_data), .fifo_pop(fifo_pop), .wr_valid(wr_valid),
        .wr_data(wr_data), .shift_done(shift_done), .sclk_next(sclk_next),
        .par_err(par_err), .ovr_evt(ovr_evt), .stat_rd(stat_rd),
        .shift_load(shift_load), .shift_data(shift_data), .buf_full(buf_full),
        .stat_err(stat_err), .stat_ovr(stat_ovr)
    );

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_word(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s shift_data: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic fifo_has();
        return fifo_en && !fifo_empty;
    endfunction

    function automatic logic model_req();
        return sclk_next && (!m_busy || shift_done);
    endfunction

    // expected combinational pop (R3)
    function automatic logic exp_pop();
        logic req = model_req();
        logic pop_load = req && !m_vld && fifo_has();
        logic freed = !m_vld || (req && m_vld);
        return pop_load || (freed && fifo_has());
    endfunction

    task automatic model_step();
        logic req      = model_req();
        logic fh       = fifo_has();
        logic ld       = req && (m_vld || fh);
        logic starve   = req && !m_vld && !fh;
        logic from_buf = req && m_vld;
        logic freed    = !m_vld || from_buf;
        logic refill   = freed && fh && !(req && !m_vld);
        if (ld) m_ldata = m_vld ? m_buf : fifo_data;
        m_load = ld;
        if (refill) begin
            m_vld = 1; m_buf = fifo_data;
        end else if (freed && !fifo_en && wr_valid) begin
            m_vld = 1; m_buf = wr_data;
        end else if (from_buf) begin
            m_vld = 0;
        end
        if (ld) m_busy = 1;
        else if (shift_done) m_busy = 0;
        m_unr = (mode_io && clk_is_input && dbuf_en && starve) || (m_unr && !stat_rd);
        m_par = (!mode_io && par_err) || (m_par && !stat_rd);
        m_ovr = (ovr_evt && !(mode_io && !clk_is_input)) || (m_ovr && !stat_rd);
    endtask

    // inputs are already driven at a falling edge
    task automatic step();
        #1;
        check(fifo_pop, exp_pop(), "R3", "fifo_pop");
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(shift_load, m_load, m_load ? "R2" : "R11", "shift_load");
        if (m_load) check_word(shift_data, m_ldata, "R2");
        check(buf_full, m_vld, "R4", "buf_full");
        check(stat_err, mode_io ? m_unr : m_par, mode_io ? cur_tag : "R8", "stat_err");
        check(stat_ovr, m_ovr, "R10", "stat_ovr");
    endtask

    task automatic idle_inputs();
        wr_valid = 0; shift_done = 0; sclk_next = 0;
        par_err = 0; ovr_evt = 0; stat_rd = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(shift_load, 0, "R1", "shift_load");
        check(buf_full, 0, "R1", "buf_full");
        check(stat_err, 0, "R1", "stat_err");
        check(stat_ovr, 0, "R1", "stat_ovr");
        check(fifo_pop, 0, "R1", "fifo_pop");

        // R2, R4: direct write then hand-off
        mode_io = 1; clk_is_input = 1; dbuf_en = 1; fifo_en = 0; fifo_empty = 1;
        idle_inputs(); wr_valid = 1; wr_data = 8'hA5; step();
        idle_inputs(); wr_valid = 1; wr_data = 8'h11; step();   // R4: ignored, buffer full
        idle_inputs(); sclk_next = 1; step();                    // R2: load A5
        // R11: busy shifter, clock ignored
        cur_tag = "R11";
        idle_inputs(); sclk_next = 1; step();
        // R5: shift_done with the clock and nothing queued
        cur_tag = "R5";
        idle_inputs(); sclk_next = 1; shift_done = 1; step();
        // R9: read clears, set wins
        cur_tag = "R9";
        idle_inputs(); stat_rd = 1; step();
        idle_inputs(); stat_rd = 1; sclk_next = 1; step();
        idle_inputs(); stat_rd = 1; step();
        // R6: clock output, no underrun
        cur_tag = "R6";
        clk_is_input = 0;
        idle_inputs(); sclk_next = 1; step();
        // R7: double buffer off, no underrun
        cur_tag = "R7";
        clk_is_input = 1; dbuf_en = 0;
        idle_inputs(); sclk_next = 1; step();
        // R3: FIFO refill and FIFO bypass load
        cur_tag = "R3";
        dbuf_en = 1; fifo_en = 1; fifo_empty = 0; fifo_data = 8'h3C;
        idle_inputs(); wr_valid = 1; wr_data = 8'h77; step();    // R4: write ignored, FIFO refills
        fifo_data = 8'h5A;
        idle_inputs(); sclk_next = 1; step();                    // load 3C, refill 5A
        fifo_empty = 1;
        idle_inputs(); sclk_next = 1; shift_done = 1; step();    // load 5A
        fifo_empty = 0; fifo_data = 8'hC3;
        idle_inputs(); shift_done = 1; step();
        // R8: parity in UART mode, mux by mode
        mode_io = 0; fifo_en = 0; fifo_empty = 1;
        idle_inputs(); par_err = 1; step();
        mode_io = 1; cur_tag = "R8";
        idle_inputs(); par_err = 1; step();
        // R10: overrun suppressed with clock output in I/O mode
        clk_is_input = 0;
        idle_inputs(); ovr_evt = 1; stat_rd = 1; step();
        clk_is_input = 1;
        idle_inputs(); ovr_evt = 1; step();
        idle_inputs(); stat_rd = 1; step();

        // constrained random
        cur_tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            if (i % 60 == 0) begin
                mode_io      = ($urandom % 4) != 0;
                clk_is_input = ($urandom % 4) != 0;
                dbuf_en      = ($urandom % 4) != 0;
                fifo_en      = $urandom % 2;
            end
            wr_valid   = ($urandom % 10) < 4;
            wr_data    = DW'($urandom);
            fifo_empty = ($urandom % 2) == 0;
            fifo_data  = DW'($urandom);
            shift_done = ($urandom % 10) < 3;
            sclk_next  = ($urandom % 10) < 4;
            par_err    = ($urandom % 10) == 0;
            ovr_evt    = ($urandom % 10) == 0;
            stat_rd    = ($urandom % 10) == 0;
            step();
        end
        finish_run();
    end

endmodule